// File: doc/BRIEF.md
# DMA and Interrupt Cycle Sequencer

This controller decides which kind of machine cycle runs next in a small processor core. Normally the core sits in execute cycles. These are owned by the instruction datapath, which signals their end with a one-cycle strobe. At that point, and at the end of every DMA cycle, the sequencer looks at the pending requests. It then inserts a DMA-in cycle, a DMA-out cycle, or an interrupt entry cycle, or it lets execution continue. DMA cycles use a 16-bit pointer. They address memory through it and step it by one after each transfer, so a device can stream a block of bytes in either direction without the program running.

An interrupt entry cycle saves the two 4-bit register selectors into an 8-bit save register. It then masks further interrupts and forces the selectors to fixed values, so the next execute cycle runs the service routine. A load mode parks the controller in an idle state. In that state the address-latch strobe is held low, and only DMA-in writes are expected, so memory can be filled from outside before the program starts.

The execute datapath may rewrite the selectors and the enable flag through a context-load input. That input only takes effect during execute cycles.

Top module: `dma_irq_seq`

## Requirements
- R1: In a DMA-in cycle (state code 1) the write strobe is high, the read strobe is low and the I/O device drives the bus. The address equals the pointer, and the pointer is one higher in the following cycle.
- R2: In a DMA-out cycle (state code 2) the read strobe is high, the write strobe is low and memory drives the bus. The address equals the pointer, and the pointer then advances by one.
- R3: Where a new cycle is chosen, a pending DMA-in request wins over a pending DMA-out request. Any DMA request wins over load mode and over an interrupt. DMA cycles repeat back to back while requests stay high.
- R4: An interrupt cycle (state code 3) leaves the save register holding {X, P} with X in bits 7:4. It clears the enable flag and sets P to 1 and X to 2.
- R5: During an interrupt cycle both strobes are low and neither the device nor memory drives the bus.
- R6: The cycle after an interrupt cycle is always an execute cycle (state code 0), whatever requests are pending.
- R7: With load mode high and no DMA request at a decision point, the controller enters idle (state code 4). Idle keeps the address strobe low and lasts until a DMA request arrives or load mode drops.
- R8: An interrupt request is taken only when the enable flag is 1 and no DMA request is pending at the decision point.
- R9: The pointer wraps from 16'hFFFF to 16'h0000.
- R10: Reset sets the enable flag to 1, clears P, X, T and the pointer, and enters the execute state.
- R11: An execute cycle lasts until the end-of-execute strobe is seen high.
- R12: A context load of P, X and the enable flag takes effect only in execute cycles. In any other cycle it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_in_req | input | 1 | Device wants to write a byte to memory |
| dma_out_req | input | 1 | Device wants a byte read from memory |
| irq_req | input | 1 | Interrupt request |
| load_mode | input | 1 | Park in idle and wait for DMA |
| exec_done | input | 1 | Last clock of the current execute cycle |
| ctx_load | input | 1 | Execute datapath writes P, X and enable |
| ctx_p | input | 4 | New P value |
| ctx_x | input | 4 | New X value |
| ctx_ie | input | 1 | New enable value |
| mem_addr | output | 16 | DMA pointer, used as the memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_drives_bus | output | 1 | I/O device owns the data bus |
| mem_drives_bus | output | 1 | Memory owns the data bus |
| addr_strobe | output | 1 | Address-latch timing strobe |
| state_code | output | 3 | 0 execute, 1 DMA-in, 2 DMA-out, 3 interrupt, 4 idle |
| p_sel | output | 4 | Program-counter selector P |
| x_sel | output | 4 | Data-pointer selector X |
| t_save | output | 8 | Save register T |
| ie | output | 1 | Interrupt enable flag |

## Verification
The pointer wrap is the hardest case to reach from the ports. The pointer only moves by one per DMA cycle, so the stimulus holds the DMA-in request high across 65,536 back-to-back DMA cycles from a known start, then confirms the address has returned to that value. The interrupt save only shows anything when the selectors are non-zero. Since the selectors can only be changed by a context load during an execute cycle, the bench first loads distinctive selector values and re-enables interrupts before it raises the request. A long random phase then mixes the requests, the context loads and load mode against a behavioural model, to reach the three-way collisions at decision points.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    typedef enum logic [2:0] {
        ST_EXEC    = 3'd0,
        ST_DMA_IN  = 3'd1,
        ST_DMA_OUT = 3'd2,
        ST_IRQ     = 3'd3,
        ST_IDLE    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic dma_in;
        logic dma_out;
        logic irq;
        logic load;
    } req_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic io_drv;
        logic mem_drv;
        logic addr_stb;
        logic ptr_step;
        logic ctx_save;
        logic ctx_open;
    } cyc_ctl_t;

    // Fixed priority: DMA-in, DMA-out, load idle, interrupt, execute.
    function automatic seq_state_e pick_next(req_t r, logic ie_now);
        seq_state_e n;
        if (r.dma_in)             n = ST_DMA_IN;
        else if (r.dma_out)       n = ST_DMA_OUT;
        else if (r.load)          n = ST_IDLE;
        else if (r.irq && ie_now) n = ST_IRQ;
        else                      n = ST_EXEC;
        return n;
    endfunction

    function automatic cyc_ctl_t ctl_of(seq_state_e s);
        cyc_ctl_t c;
        c = '0;
        c.addr_stb = 1'b1;
        unique case (s)
            ST_DMA_IN: begin
                c.wr       = 1'b1;
                c.io_drv   = 1'b1;
                c.ptr_step = 1'b1;
            end
            ST_DMA_OUT: begin
                c.rd       = 1'b1;
                c.mem_drv  = 1'b1;
                c.ptr_step = 1'b1;
            end
            ST_IRQ:  c.ctx_save = 1'b1;
            ST_IDLE: c.addr_stb = 1'b0;
            default: c.ctx_open = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seq_arbiter.sv
module seq_arbiter
    import seqctl_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       exec_done,
    input  req_t       req,
    input  logic       ie_now,
    output seq_state_e nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_EXEC:
                if (exec_done) nxt_state = pick_next(req, ie_now);
            ST_DMA_IN, ST_DMA_OUT:
                nxt_state = pick_next(req, ie_now);
            ST_IRQ:
                nxt_state = ST_EXEC;
            ST_IDLE: begin
                if (req.dma_in)       nxt_state = ST_DMA_IN;
                else if (req.dma_out) nxt_state = ST_DMA_OUT;
                else if (!req.load)   nxt_state = ST_EXEC;
                else                  nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_EXEC;
        endcase
    end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seqctl_pkg::*;
(
    input  seq_state_e cur_state,
    output cyc_ctl_t   ctl
);
    always_comb ctl = ctl_of(cur_state);
endmodule

// File: rtl/seq_ptr.sv
module seq_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (step) ptr <= ptr + ONE;
    end
endmodule

// File: rtl/seq_ctx_regs.sv
module seq_ctx_regs
    import seqctl_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int IRQ_P = 1,
    parameter int IRQ_X = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  cyc_ctl_t           ctl,
    input  logic               ctx_load,
    input  logic [SEL_W-1:0]   ctx_p,
    input  logic [SEL_W-1:0]   ctx_x,
    input  logic               ctx_ie,
    output logic [SEL_W-1:0]   p_q,
    output logic [SEL_W-1:0]   x_q,
    output logic [2*SEL_W-1:0] t_q,
    output logic               ie_q
);
    localparam logic [SEL_W-1:0] P_VEC = SEL_W'(IRQ_P);
    localparam logic [SEL_W-1:0] X_VEC = SEL_W'(IRQ_X);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q  <= '0;
            x_q  <= '0;
            t_q  <= '0;
            ie_q <= 1'b1;
        end else if (ctl.ctx_save) begin
            t_q  <= {x_q, p_q};
            p_q  <= P_VEC;
            x_q  <= X_VEC;
            ie_q <= 1'b0;
        end else if (ctl.ctx_open && ctx_load) begin
            p_q  <= ctx_p;
            x_q  <= ctx_x;
            ie_q <= ctx_ie;
        end
    end
endmodule

// File: rtl/dma_irq_seq.sv
module dma_irq_seq
    import seqctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 4,
    parameter int IRQ_P  = 1,
    parameter int IRQ_X  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_in_req,
    input  logic               dma_out_req,
    input  logic               irq_req,
    input  logic               load_mode,
    input  logic               exec_done,
    input  logic               ctx_load,
    input  logic [SEL_W-1:0]   ctx_p,
    input  logic [SEL_W-1:0]   ctx_x,
    input  logic               ctx_ie,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               io_drives_bus,
    output logic               mem_drives_bus,
    output logic               addr_strobe,
    output logic [2:0]         state_code,
    output logic [SEL_W-1:0]   p_sel,
    output logic [SEL_W-1:0]   x_sel,
    output logic [2*SEL_W-1:0] t_save,
    output logic               ie
);
    seq_state_e state_q, state_d;
    cyc_ctl_t   ctl;
    req_t       req;

    assign req = '{dma_in: dma_in_req, dma_out: dma_out_req,
                   irq: irq_req, load: load_mode};

    seq_arbiter u_arb (
        .cur_state (state_q),
        .exec_done (exec_done),
        .req       (req),
        .ie_now    (ie),
        .nxt_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EXEC;
        else     state_q <= state_d;
    end

    seq_decode u_dec (
        .cur_state (state_q),
        .ctl       (ctl)
    );

    seq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (ctl.ptr_step),
        .ptr  (mem_addr)
    );

    seq_ctx_regs #(.SEL_W(SEL_W), .IRQ_P(IRQ_P), .IRQ_X(IRQ_X)) u_ctx (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .ctx_load (ctx_load),
        .ctx_p    (ctx_p),
        .ctx_x    (ctx_x),
        .ctx_ie   (ctx_ie),
        .p_q      (p_sel),
        .x_q      (x_sel),
        .t_q      (t_save),
        .ie_q     (ie)
    );

    assign mem_rd         = ctl.rd;
    assign mem_wr         = ctl.wr;
    assign io_drives_bus  = ctl.io_drv;
    assign mem_drives_bus = ctl.mem_drv;
    assign addr_strobe    = ctl.addr_stb;
    assign state_code     = state_q;
endmodule

// File: rtl/dma_irq_seq_chk.sv
module dma_irq_seq_chk
    import seqctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               dma_in_req,
    input logic               irq_req,
    input logic               exec_done,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               io_drives_bus,
    input logic               mem_drives_bus,
    input logic               addr_strobe,
    input logic [2:0]         state_code,
    input logic [SEL_W-1:0]   p_sel,
    input logic [SEL_W-1:0]   x_sel,
    input logic [2*SEL_W-1:0] t_save,
    input logic               ie
);
    logic in_dma;
    assign in_dma = (state_code == ST_DMA_IN) || (state_code == ST_DMA_OUT);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        in_dma |=> mem_addr == $past(mem_addr) + 1'b1); // R1
    AST_DMA_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_DMA_IN |-> mem_wr && !mem_rd && io_drives_bus && !mem_drives_bus); // R1
    AST_DMA_OUT_READ: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_DMA_OUT |-> mem_rd && !mem_wr && mem_drives_bus && !io_drives_bus); // R2
    AST_IN_WINS: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_EXEC && exec_done && dma_in_req) |=> state_code == ST_DMA_IN); // R3
    AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_IRQ |=> t_save == {$past(x_sel), $past(p_sel)} && p_sel == 4'd1 && x_sel == 4'd2 && !ie); // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_IRQ |-> !mem_rd && !mem_wr && !io_drives_bus && !mem_drives_bus); // R5
    AST_IRQ_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_IRQ |=> state_code == ST_EXEC); // R6
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_IDLE |-> !addr_strobe); // R7
    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_EXEC && !ie && irq_req) |=> state_code != ST_IRQ); // R8
    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_EXEC && !exec_done) |=> state_code == ST_EXEC); // R11
    AST_RESET_VALUES: assert property (@(posedge clk)
        rst |=> state_code == ST_EXEC && mem_addr == '0 && ie && p_sel == '0 && x_sel == '0); // R10
endmodule

bind dma_irq_seq dma_irq_seq_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dma_in_req     (dma_in_req),
    .irq_req        (irq_req),
    .exec_done      (exec_done),
    .mem_addr       (mem_addr),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .io_drives_bus  (io_drives_bus),
    .mem_drives_bus (mem_drives_bus),
    .addr_strobe    (addr_strobe),
    .state_code     (state_code),
    .p_sel          (p_sel),
    .x_sel          (x_sel),
    .t_save         (t_save),
    .ie             (ie)
);

// File: tb/sim_dma_irq_seq.sv
module sim_dma_irq_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_in_req = 0, dma_out_req = 0, irq_req = 0, load_mode = 0, exec_done = 0;
    logic ctx_load = 0, ctx_ie = 0;
    logic [3:0] ctx_p = 0, ctx_x = 0;
    logic [15:0] mem_addr;
    logic mem_rd, mem_wr, io_drives_bus, mem_drives_bus, addr_strobe, ie;
    logic [2:0] state_code;
    logic [3:0] p_sel, x_sel;
    logic [7:0] t_save;

    always #5 clk = ~clk;

    dma_irq_seq u0 (.*);

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // behavioural reference
    int m_st, m_ptr, m_p, m_x, m_t, m_ie;

    task automatic fail_line(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    function automatic string req_of(int s);
        case (s)
            1: return "R1";
            2: return "R2";
            3: return "R5";
            4: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic compare_model();
        string r = req_of(m_st);
        vectors++;
        if (state_code != m_st) fail_line("R3", "state", state_code, m_st);
        if (mem_addr != m_ptr[15:0]) fail_line("R9", "addr", mem_addr, m_ptr);
        if (mem_wr != (m_st == 1)) fail_line(r, "wr", mem_wr, m_st == 1);
        if (io_drives_bus != (m_st == 1)) fail_line(r, "io_drv", io_drives_bus, m_st == 1);
        if (mem_rd != (m_st == 2)) fail_line(r, "rd", mem_rd, m_st == 2);
        if (mem_drives_bus != (m_st == 2)) fail_line(r, "mem_drv", mem_drives_bus, m_st == 2);
        if (addr_strobe != (m_st != 4)) fail_line(r, "strobe", addr_strobe, m_st != 4);
        if (p_sel != m_p || x_sel != m_x) fail_line("R12", "p/x", {x_sel, p_sel}, m_x * 16 + m_p);
        if (t_save != m_t) fail_line("R4", "t", t_save, m_t);
        if (ie != m_ie) fail_line("R8", "ie", ie, m_ie);
    endtask

    function automatic int pick(bit din, bit dout, bit ld, bit irq);
        if (din) return 1;
        if (dout) return 2;
        if (ld) return 4;
        if (irq && m_ie != 0) return 3;
        return 0;
    endfunction

    task automatic tick(bit din, bit dout, bit irq, bit ld, bit done,
                        bit cl = 0, int cp = 0, int cx = 0, bit cie = 0);
        int nst;
        dma_in_req = din; dma_out_req = dout; irq_req = irq; load_mode = ld;
        exec_done = done; ctx_load = cl; ctx_p = cp[3:0]; ctx_x = cx[3:0]; ctx_ie = cie;
        nst = m_st;
        case (m_st)
            0: begin
                if (done) nst = pick(din, dout, ld, irq);
                if (cl) begin m_p = cp; m_x = cx; m_ie = cie; end
            end
            1, 2: begin
                nst = pick(din, dout, ld, irq);
                m_ptr = (m_ptr + 1) % 65536;
            end
            3: begin
                m_t = m_x * 16 + m_p; m_p = 1; m_x = 2; m_ie = 0; nst = 0;
            end
            default: nst = din ? 1 : dout ? 2 : !ld ? 0 : 4;
        endcase
        m_st = nst;
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int start;
        m_st = 0; m_ptr = 0; m_p = 0; m_x = 0; m_t = 0; m_ie = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset values
        chk("R10", "state", state_code, 0);
        chk("R10", "addr", mem_addr, 0);
        chk("R10", "ie", ie, 1);
        chk("R10", "p/x/t", {p_sel, x_sel, t_save}, 0);
        compare_model();

        // R11: no end strobe, requests wait
        tick(1, 0, 0, 0, 0);
        chk("R11", "state hold", state_code, 0);
        // R3: both DMA requests, in first; then out; then back to execute
        tick(1, 1, 1, 0, 1);
        chk("R3", "in first", state_code, 1);
        chk("R1", "write strobe", mem_wr, 1);
        tick(0, 1, 0, 0, 0, 1, 7, 7, 0);  // context load in DMA cycle
        chk("R2", "dma out", state_code, 2);
        chk("R1", "pointer step", mem_addr, 1);
        chk("R12", "ignored load", {p_sel, x_sel}, 0);
        tick(0, 0, 0, 0, 0);
        chk("R2", "pointer step", mem_addr, 2);
        chk("R3", "back to exec", state_code, 0);
        // R8: interrupt with DMA pending -> DMA wins
        tick(0, 0, 0, 0, 0, 1, 5, 9, 1);
        chk("R12", "load in exec", {x_sel, p_sel}, 8'h95);
        tick(1, 0, 1, 0, 1);
        chk("R8", "dma over irq", state_code, 1);
        tick(0, 0, 1, 0, 0);
        chk("R8", "irq after dma", state_code, 3);
        chk("R5", "quiet bus", {mem_rd, mem_wr, io_drives_bus, mem_drives_bus}, 0);
        tick(1, 1, 1, 0, 0);
        chk("R6", "exec after irq", state_code, 0);
        chk("R4", "t save", t_save, 8'h95);
        chk("R4", "p/x forced", {x_sel, p_sel}, 8'h21);
        chk("R4", "ie cleared", ie, 0);
        tick(0, 0, 1, 0, 1);
        chk("R8", "masked irq", state_code, 0);
        // R7: load idle
        tick(0, 0, 1, 1, 1);
        chk("R7", "idle", state_code, 4);
        chk("R7", "no strobe", addr_strobe, 0);
        repeat (5) tick(0, 0, 1, 1, 1);
        chk("R7", "idle holds", state_code, 4);
        // R9: wrap after a full burst of DMA-in
        start = mem_addr;
        repeat (65536) tick(1, 0, 0, 1, 0);
        tick(0, 0, 0, 1, 0);
        chk("R9", "wrap", mem_addr, (start + 65536) % 65536);
        tick(0, 0, 0, 0, 0);
        chk("R7", "leave idle", state_code, 0);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            int v = $urandom;
            tick(v[0] & v[1], v[2] & v[3], v[4], v[5] & v[6] & v[7], v[8],
                 v[9] & v[10], v[14:11], v[18:15], v[19]);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule